// File: doc/BRIEF.md
# Varicode Character Serializer

This block turns a queue of 7-bit ASCII characters into the serial varicode bit stream that a phase-shift-keyed audio modulator consumes. Characters are pushed into a 256-slot circular character store through a simple write strobe. The modulator asks for bits one at a time with a request pulse. Each character is translated by an internal 128-entry code table and shifted out least significant bit first. The block presents the current bit at `bit_out` before the request that consumes it.

No code word contains two adjacent zeros. Character boundaries are therefore not signalled by a length. The serializer keeps sending zeros after a code's last one and counts the run of consecutive zeros. When that run passes a threshold of 2, the next character is loaded. If the store is empty at that point, the threshold is raised to 75 so that a long idle run of zeros is sent. If the store is still empty when that run ends, the block raises `done` and stops advancing. A later write wakes it again.

Top module: `varicode_serializer`

## Requirements
- R1: After reset, `done` is 1, `bit_out` is 0 and `overflow` is 0. While `done` is 1, `bit_req` pulses change neither `bit_out` (held at 0) nor `done`.
- R2: A write while `done` is 1 clears `done` on the next clock. The restarted stream begins with three zero bits before the first code bit of that character.
- R3: Each character value 0..127 maps to a 16-bit code, sent bit 0 first. Examples: space (32) is 0x0001, 'e' (101) is 0x0003, 't' (116) is 0x0005, 'i' (105) is 0x000B, 'n' (110) is 0x000F, CR (13) is 0x001F, LF (10) is 0x0017, NUL (0) is 0x0355, '?' (63) is 0x03D5, 64 is 0x02F5 and DEL (127) is 0x02B7. `bit_out` shows the current bit and moves to the next one on the clock edge that samples `bit_req` high.
- R4: The consecutive-zero counter restarts on every 1 bit. The request that sends the third consecutive zero after a code's highest 1 bit loads the next stored character. Back-to-back characters are therefore separated by exactly three zeros.
- R5: Every one of the 128 codes is nonzero, has bit 0 set, fits in 16 bits, has no two adjacent zero bits below its highest 1 bit, and differs from all other codes.
- R6: Characters are sent in write order. The store holds at most 255 unsent characters, and its read and write indices wrap from 255 to 0.
- R7: A write while 255 characters are pending is discarded and sets `overflow`. `overflow` stays set until reset.
- R8: If the store is empty at a character end, 76 further zero bits are sent (threshold 75). The request that sends the 76th of them sets `done`. That gives 79 zeros after the last code bit.
- R9: A character written during the idle run is sent only after the full idle run, as for a non-empty store at that point. The threshold then returns to 2, so the following character again comes after three zeros.
- R10: A write in the same clock as the request that would stop transmission keeps `done` at 0. The stream restarts with three zeros and then the new character.
- R11: A write in the same clock as a character-end request that finds the store empty does not take part in that decision. The idle run starts, and the written character follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one character |
| wr_char | input | 7 | ASCII character to queue |
| bit_req | input | 1 | Request from the modulator to advance one bit |
| bit_out | output | 1 | Current stream bit |
| done | output | 1 | Transmission stopped after the idle run |
| overflow | output | 1 | Sticky flag: a write was dropped because the store was full |

## Verification
The write port and the bit engine's end-of-character decision can act in the same clock. A queued character may arrive exactly when the engine samples the store as empty or decides to stop. The bench provokes both cases by raising `wr_en` together with `bit_req` on the third trailing zero of a character and on the 76th zero of the idle run. It judges the outcome from the number of zeros before the new code appears (79 in the first case, 3 in the second) and from `done` staying low in the second case. A sweep over all 128 characters, each sent alone from the stopped state, checks the shape and uniqueness of every code and the full idle sequence after each one.

// File: rtl/vcser_pkg.sv
package vcser_pkg;

    localparam int CHAR_W = 7;
    localparam int CODE_W = 16;
    localparam int RUN_W  = 8;

    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [RUN_W-1:0]  run_t;

    // Bit-engine state: shift register, zero-run count, idle-run mode, stopped.
    typedef struct packed {
        code_t shreg;
        run_t  zrun;
        logic  tail_mode;
        logic  done;
    } eng_state_t;

    // Codes for character values 0..63, bit 0 is sent first.
    function automatic code_t vc_code_lo(input logic [5:0] idx);
        code_t r;
        case (idx)
            6'd0:  r = 16'h0355; 6'd1:  r = 16'h036d; 6'd2:  r = 16'h02dd; 6'd3:  r = 16'h03bb;
            6'd4:  r = 16'h035d; 6'd5:  r = 16'h03eb; 6'd6:  r = 16'h03dd; 6'd7:  r = 16'h02fd;
            6'd8:  r = 16'h03fd; 6'd9:  r = 16'h00f7; 6'd10: r = 16'h0017; 6'd11: r = 16'h03db;
            6'd12: r = 16'h02ed; 6'd13: r = 16'h001f; 6'd14: r = 16'h02bb; 6'd15: r = 16'h0357;
            6'd16: r = 16'h03bd; 6'd17: r = 16'h02bd; 6'd18: r = 16'h02d7; 6'd19: r = 16'h03d7;
            6'd20: r = 16'h036b; 6'd21: r = 16'h035b; 6'd22: r = 16'h02db; 6'd23: r = 16'h03ab;
            6'd24: r = 16'h037b; 6'd25: r = 16'h02fb; 6'd26: r = 16'h03b7; 6'd27: r = 16'h02ab;
            6'd28: r = 16'h02eb; 6'd29: r = 16'h0377; 6'd30: r = 16'h037d; 6'd31: r = 16'h03fb;
            6'd32: r = 16'h0001; 6'd33: r = 16'h01ff; 6'd34: r = 16'h01f5; 6'd35: r = 16'h015f;
            6'd36: r = 16'h01b7; 6'd37: r = 16'h02ad; 6'd38: r = 16'h0375; 6'd39: r = 16'h01fd;
            6'd40: r = 16'h00df; 6'd41: r = 16'h00ef; 6'd42: r = 16'h01ed; 6'd43: r = 16'h01f7;
            6'd44: r = 16'h0057; 6'd45: r = 16'h002b; 6'd46: r = 16'h0075; 6'd47: r = 16'h01eb;
            6'd48: r = 16'h00ed; 6'd49: r = 16'h00bd; 6'd50: r = 16'h00b7; 6'd51: r = 16'h00ff;
            6'd52: r = 16'h01dd; 6'd53: r = 16'h01b5; 6'd54: r = 16'h01ad; 6'd55: r = 16'h016b;
            6'd56: r = 16'h01ab; 6'd57: r = 16'h01db; 6'd58: r = 16'h00af; 6'd59: r = 16'h017b;
            6'd60: r = 16'h016f; 6'd61: r = 16'h0055; 6'd62: r = 16'h01d7; 6'd63: r = 16'h03d5;
            default: r = '0;
        endcase
        return r;
    endfunction

    // Codes for character values 64..127, indexed by the low six bits.
    function automatic code_t vc_code_hi(input logic [5:0] idx);
        code_t r;
        case (idx)
            6'd0:  r = 16'h02f5; 6'd1:  r = 16'h005f; 6'd2:  r = 16'h00d7; 6'd3:  r = 16'h00b5;
            6'd4:  r = 16'h00ad; 6'd5:  r = 16'h0077; 6'd6:  r = 16'h00db; 6'd7:  r = 16'h00bf;
            6'd8:  r = 16'h0155; 6'd9:  r = 16'h007f; 6'd10: r = 16'h017f; 6'd11: r = 16'h017d;
            6'd12: r = 16'h00eb; 6'd13: r = 16'h00dd; 6'd14: r = 16'h00bb; 6'd15: r = 16'h00d5;
            6'd16: r = 16'h00ab; 6'd17: r = 16'h0177; 6'd18: r = 16'h00f5; 6'd19: r = 16'h007b;
            6'd20: r = 16'h005b; 6'd21: r = 16'h01d5; 6'd22: r = 16'h015b; 6'd23: r = 16'h0175;
            6'd24: r = 16'h015d; 6'd25: r = 16'h01bd; 6'd26: r = 16'h02d5; 6'd27: r = 16'h01df;
            6'd28: r = 16'h01ef; 6'd29: r = 16'h01bf; 6'd30: r = 16'h03f5; 6'd31: r = 16'h016d;
            6'd32: r = 16'h03ed; 6'd33: r = 16'h000d; 6'd34: r = 16'h007d; 6'd35: r = 16'h003d;
            6'd36: r = 16'h002d; 6'd37: r = 16'h0003; 6'd38: r = 16'h002f; 6'd39: r = 16'h006d;
            6'd40: r = 16'h0035; 6'd41: r = 16'h000b; 6'd42: r = 16'h01af; 6'd43: r = 16'h00fd;
            6'd44: r = 16'h001b; 6'd45: r = 16'h0037; 6'd46: r = 16'h000f; 6'd47: r = 16'h0007;
            6'd48: r = 16'h003f; 6'd49: r = 16'h01fb; 6'd50: r = 16'h0015; 6'd51: r = 16'h001d;
            6'd52: r = 16'h0005; 6'd53: r = 16'h003b; 6'd54: r = 16'h006f; 6'd55: r = 16'h006b;
            6'd56: r = 16'h00fb; 6'd57: r = 16'h005d; 6'd58: r = 16'h0157; 6'd59: r = 16'h03b5;
            6'd60: r = 16'h01bb; 6'd61: r = 16'h02b5; 6'd62: r = 16'h03ad; 6'd63: r = 16'h02b7;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic code_t vc_code(input char_t ch);
        return ch[CHAR_W-1] ? vc_code_hi(ch[CHAR_W-2:0]) : vc_code_lo(ch[CHAR_W-2:0]);
    endfunction

endpackage

// File: rtl/vcser_code_rom.sv
module vcser_code_rom
    import vcser_pkg::*;
(
    input  char_t ch,
    output code_t code
);

    assign code = vc_code(ch);

endmodule

// File: rtl/vcser_char_ring.sv
module vcser_char_ring
    import vcser_pkg::*;
#(
    parameter int unsigned PTR_W = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  char_t push_data,
    input  logic  pop,
    output char_t head_data,
    output logic  empty,
    output logic  push_ok,
    output logic  overflow
);

    localparam int unsigned DEPTH = 1 << PTR_W;
    typedef logic [PTR_W-1:0] ptr_t;
    localparam ptr_t PTR_ONE = ptr_t'(1);

    char_t mem [DEPTH];
    ptr_t  head;
    ptr_t  tail;
    ptr_t  tail_next;
    logic  full;

    assign tail_next = tail + PTR_ONE;
    assign full      = (tail_next == head);
    assign empty     = (head == tail);
    assign push_ok   = push && !full;
    assign head_data = mem[head];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[tail] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head     <= '0;
            tail     <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) begin
                tail <= tail_next;
            end
            if (push && full) begin
                overflow <= 1'b1;
            end
            if (pop && !empty) begin
                head <= head + PTR_ONE;
            end
        end
    end

endmodule

// File: rtl/vcser_bit_engine.sv
module vcser_bit_engine
    import vcser_pkg::*;
#(
    parameter int unsigned END_RUN  = 2,
    parameter int unsigned IDLE_RUN = 75
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_req,
    input  logic  empty,
    input  code_t code,
    input  logic  wake,
    output logic  fetch,
    output logic  bit_out,
    output logic  done
);

    localparam run_t END_LIM  = run_t'(END_RUN);
    localparam run_t IDLE_LIM = run_t'(IDLE_RUN);

    eng_state_t cur;
    eng_state_t nxt;
    logic       step;
    logic       char_end;
    logic       stop;
    run_t       zinc;
    run_t       limit;

    always_comb begin
        step     = bit_req && !cur.done;
        zinc     = cur.shreg[0] ? '0 : run_t'(cur.zrun + 1'b1);
        limit    = cur.tail_mode ? IDLE_LIM : END_LIM;
        char_end = step && !cur.shreg[0] && (zinc > limit);
        fetch    = char_end && !empty;
        stop     = char_end && empty && cur.tail_mode;

        nxt = cur;
        if (step) begin
            nxt.shreg = cur.shreg >> 1;
            nxt.zrun  = zinc;
        end
        if (char_end) begin
            nxt.zrun = '0;
            if (!empty) begin
                nxt.shreg     = code;
                nxt.tail_mode = 1'b0;
            end else if (!cur.tail_mode) begin
                nxt.tail_mode = 1'b1;
            end else begin
                nxt.done = 1'b1;
            end
        end
        // A queued character revives a stopped (or stopping) engine.
        if (wake && (cur.done || stop)) begin
            nxt.done      = 1'b0;
            nxt.tail_mode = 1'b0;
            nxt.zrun      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.shreg     <= '0;
            cur.zrun      <= '0;
            cur.tail_mode <= 1'b0;
            cur.done      <= 1'b1;
        end else begin
            cur <= nxt;
        end
    end

    assign bit_out = cur.shreg[0];
    assign done    = cur.done;

endmodule

// File: rtl/varicode_serializer.sv
module varicode_serializer
    import vcser_pkg::*;
#(
    parameter int unsigned PTR_W    = 8,
    parameter int unsigned END_RUN  = 2,
    parameter int unsigned IDLE_RUN = 75
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              bit_req,
    output logic              bit_out,
    output logic              done,
    output logic              overflow
);

    char_t head_char_w;
    code_t code_w;
    logic  empty_w;
    logic  push_ok_w;
    logic  fetch_w;

    vcser_char_ring #(
        .PTR_W(PTR_W)
    ) u_ring (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en),
        .push_data (wr_char),
        .pop       (fetch_w),
        .head_data (head_char_w),
        .empty     (empty_w),
        .push_ok   (push_ok_w),
        .overflow  (overflow)
    );

    vcser_code_rom u_rom (
        .ch   (head_char_w),
        .code (code_w)
    );

    vcser_bit_engine #(
        .END_RUN  (END_RUN),
        .IDLE_RUN (IDLE_RUN)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .bit_req (bit_req),
        .empty   (empty_w),
        .code    (code_w),
        .wake    (push_ok_w),
        .fetch   (fetch_w),
        .bit_out (bit_out),
        .done    (done)
    );

endmodule

// File: rtl/vcser_checker.sv
module vcser_checker
    import vcser_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wr_en,
    input logic  bit_req,
    input logic  bit_out,
    input logic  done,
    input logic  overflow,
    input logic  fetch,
    input code_t code
);

    p_quiet_done_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> !bit_out);

    p_wake_r2: assert property (@(posedge clk) disable iff (rst)
        (done && wr_en) |=> !done);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!bit_req && !wr_en) |=> ($stable(bit_out) && $stable(done)));

    p_code_shape_r5: assert property (@(posedge clk) disable iff (rst)
        fetch |-> (code[0] && (code != '0)));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_ovf_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(wr_en));

    p_stop_on_req_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(bit_req));

endmodule

bind varicode_serializer vcser_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .bit_req  (bit_req),
    .bit_out  (bit_out),
    .done     (done),
    .overflow (overflow),
    .fetch    (fetch_w),
    .code     (code_w)
);

// File: tb/tb_varicode_serializer.sv
`timescale 1ns/1ps
module tb_varicode_serializer;

    logic       clk;
    logic       rst;
    logic       wr_en;
    logic [6:0] wr_char;
    logic       bit_req;
    logic       bit_out;
    logic       done;
    logic       overflow;

    int checks = 0;
    int fails  = 0;
    int got [128];
    logic b;

    varicode_serializer dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_char  (wr_char),
        .bit_req  (bit_req),
        .bit_out  (bit_out),
        .done     (done),
        .overflow (overflow)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic int ref_code(input int c);
        case (c)
            32:  return 'h0001;
            101: return 'h0003;
            116: return 'h0005;
            105: return 'h000b;
            110: return 'h000f;
            13:  return 'h001f;
            10:  return 'h0017;
            0:   return 'h0355;
            63:  return 'h03d5;
            64:  return 'h02f5;
            127: return 'h02b7;
            default: return -1;
        endcase
    endfunction

    function automatic int top_bit(input int v);
        for (int i = 15; i >= 0; i--) if (v[i]) return i;
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic take_bit(output logic v);
        v = bit_out;
        bit_req = 1'b1;
        @(negedge clk);
        bit_req = 1'b0;
    endtask

    task automatic take_bit_wr(input int c, output logic v);
        v = bit_out;
        bit_req = 1'b1;
        wr_en   = 1'b1;
        wr_char = 7'(c);
        @(negedge clk);
        bit_req = 1'b0;
        wr_en   = 1'b0;
    endtask

    task automatic put_char(input int c);
        wr_en   = 1'b1;
        wr_char = 7'(c);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic expect_zeros(input int n, input string tag);
        logic v;
        for (int i = 0; i < n; i++) begin
            take_bit(v);
            check(v == 1'b0, tag, v, 0);
        end
    endtask

    task automatic expect_char(input int c, input string tag);
        logic v;
        int code;
        code = ref_code(c);
        for (int i = 0; i <= top_bit(code); i++) begin
            take_bit(v);
            check(v == code[i], tag, v, code[i]);
        end
    endtask

    // R8: 76 idle zeros, done rises only with the last one
    task automatic expect_tail(input string tag);
        expect_zeros(75, tag);
        check(done == 1'b0, {tag, " done early"}, done, 0);
        expect_zeros(1, tag);
        check(done == 1'b1, {tag, " done at end"}, done, 1);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_char = '0; bit_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state and ignored requests
        check(done == 1'b1, "R1 done after reset", done, 1);
        check(bit_out == 1'b0, "R1 bit_out after reset", bit_out, 0);
        check(overflow == 1'b0, "R1 overflow after reset", overflow, 0);
        for (int i = 0; i < 5; i++) take_bit(b);
        check(bit_out == 1'b0 && done == 1'b1, "R1 requests ignored when done", {bit_out, done}, 1);

        // R5 sweep over every character, each sent alone (also R2, R8)
        for (int c = 0; c < 128; c++) begin
            int val, pos, zr;
            bit bad;
            put_char(c);
            check(done == 1'b0, "R2 wake on write", done, 0);
            expect_zeros(3, "R2 lead zeros");
            val = 0; pos = 0; zr = 0; bad = 1'b0;
            while (zr < 3 && pos < 40) begin
                take_bit(b);
                if (b) begin
                    if (zr >= 2) bad = 1'b1;
                    if (pos < 32) val = val | (1 << pos);
                    zr = 0;
                end else begin
                    zr++;
                end
                pos++;
            end
            check(!bad && val[0] && zr == 3 && (pos - 3) <= 16 && val != 0,
                  "R5 code shape", val, c);
            got[c] = val;
            expect_tail("R8 idle run");
        end
        begin
            int dup;
            dup = 0;
            for (int a = 0; a < 128; a++)
                for (int k = a + 1; k < 128; k++)
                    if (got[a] == got[k]) dup++;
            check(dup == 0, "R5 distinct codes", dup, 0);
        end
        for (int c = 0; c < 128; c++)
            if (ref_code(c) >= 0) check(got[c] == ref_code(c), "R3 table value", got[c], ref_code(c));

        // R4 back-to-back characters
        put_char(116);
        check(done == 1'b0, "R2 wake on write", done, 0);
        put_char(101); put_char(32); put_char(13); put_char(10);
        expect_zeros(3, "R2 lead zeros");
        expect_char(116, "R3 t bits");  expect_zeros(3, "R4 gap");
        expect_char(101, "R3 e bits");  expect_zeros(3, "R4 gap");
        expect_char(32,  "R3 sp bits"); expect_zeros(3, "R4 gap");
        expect_char(13,  "R3 cr bits"); expect_zeros(3, "R4 gap");
        expect_char(10,  "R3 lf bits"); expect_zeros(3, "R4 gap");
        expect_tail("R8 idle run");

        // R9 write during the idle run
        put_char(101);
        expect_zeros(3, "R2 lead zeros");
        expect_char(101, "R3 e bits");
        expect_zeros(3, "R4 gap");
        expect_zeros(10, "R9 idle start");
        put_char(116); put_char(101);
        check(done == 1'b0, "R9 still running", done, 0);
        expect_zeros(66, "R9 idle completes");
        expect_char(116, "R9 t after idle");
        expect_zeros(3, "R9 threshold back to 2");
        expect_char(101, "R9 e after t");
        expect_zeros(3, "R4 gap");
        expect_tail("R8 idle run");

        // R11 write coinciding with a char-end that sees an empty store
        put_char(101);
        expect_zeros(3, "R2 lead zeros");
        expect_char(101, "R3 e bits");
        expect_zeros(2, "R4 gap");
        take_bit_wr(116, b);
        check(b == 1'b0, "R11 third zero", b, 0);
        expect_zeros(76, "R11 idle run still sent");
        expect_char(116, "R11 t after idle");
        expect_zeros(3, "R4 gap");
        expect_tail("R8 idle run");

        // R10 write in the stopping cycle
        put_char(101);
        expect_zeros(3, "R2 lead zeros");
        expect_char(101, "R3 e bits");
        expect_zeros(3, "R4 gap");
        expect_zeros(75, "R8 idle run");
        take_bit_wr(105, b);
        check(b == 1'b0, "R10 last idle zero", b, 0);
        check(done == 1'b0, "R10 done held low", done, 1'b0);
        expect_zeros(3, "R10 restart zeros");
        expect_char(105, "R10 i bits");
        expect_zeros(3, "R4 gap");
        expect_tail("R8 idle run");

        // R6 / R7 fill to capacity (indices wrap), overflow, drain in order
        for (int k = 0; k < 255; k++) put_char((k % 2) ? 116 : 101);
        check(overflow == 1'b0, "R7 no overflow at 255", overflow, 0);
        put_char(110);
        check(overflow == 1'b1, "R7 overflow on full write", overflow, 1);
        expect_zeros(3, "R2 lead zeros");
        for (int k = 0; k < 255; k++) begin
            expect_char((k % 2) ? 116 : 101, "R6 write order");
            expect_zeros(3, "R6 gap");
        end
        expect_tail("R7 dropped char not sent");
        check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule